// File: doc/BRIEF.md
# Card Command Response Engine

This engine sits behind a memory-card host register block. Software, through that register block, presents a 6-bit command opcode with a 32-bit argument. The engine answers with a 128-bit response (four 32-bit words), pulses a command-complete flag, and, for commands that carry data, either requests a block transfer from a storage port or writes a short fixed status record into a host buffer. It then pulses a data-complete flag.

The engine holds three pieces of state: the block length, the block count and a high-capacity mode bit. The register block loads each of them through a strobe. The mode bit selects how the argument of a block read or write is read. In high-capacity mode the argument is already a block index. In byte mode the argument is a byte offset, which a serial divider turns into a block index. A byte offset that does not sit on a 512-byte boundary raises a one-cycle warning pulse. While a transfer or a buffer fill is under way, the engine refuses new commands.

Top module: `card_cmd_engine`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high. From the next cycle, `resp_o` holds the new response, with bits 127:32 zero, and `cmd_done_o` is high for one cycle. An opcode not named in R2, R3, R11 or R12 gives an all-zero response and causes no transfer and no buffer write.
- R2: A status response has the current-state code in bits 12:9, the ready bit at bit 8 and the application-command bit at bit 5, with all other bits zero. Opcode 55 answers 0x920. Opcode 7 answers 0x700. Opcode 12 answers 0xB00. Opcodes 13, 16, 17, 18, 24 and 25 answer 0x900.
- R3: Opcode 41 answers 0x80FF8000. Opcode 8 returns the argument unchanged in bits 31:0.
- R4: The block length resets to 512. A `len_wr_i` strobe stores `len_val_i`+1, modulo 2^LEN_W. Opcode 16 stores argument bits LEN_W-1:0. If both happen in the same cycle, opcode 16 wins.
- R5: The block count resets to 1. A `cnt_wr_i` strobe stores `cnt_val_i`+1, modulo 2^CNT_W. Opcodes 17 and 24 transfer one block and leave the stored count at 1; this beats a same-cycle strobe. Opcodes 18 and 25 transfer the count stored before the command.
- R6: Opcodes 17 and 18 read (`xfer_wr_o`=0); opcodes 24 and 25 write (`xfer_wr_o`=1). In high-capacity mode, `xfer_idx_o` equals the argument and `xfer_req_o` is high from the first cycle after acceptance.
- R7: In byte mode, `xfer_idx_o` is the argument divided by the block length, rounded down, or all ones if the length is 0. `xfer_req_o` first goes high 34 cycles after acceptance.
- R8: `align_warn_o` pulses together with `cmd_done_o` for opcodes 17, 18, 24 and 25 in byte mode when argument bits 8:0 are not all zero. It never pulses in high-capacity mode.
- R9: `xfer_req_o` stays high, with `xfer_idx_o`, `xfer_cnt_o` and `xfer_wr_o` held stable, until `xfer_ack_i` is sampled high. In the next cycle `xfer_req_o` is low, `data_done_o` pulses for one cycle and `cmd_ready_o` is high.
- R10: `cmd_ready_o` is low from acceptance of a transfer or fill command until `data_done_o`. Any `cmd_valid_i` during that time is ignored and leaves `resp_o` unchanged.
- R11: Opcode 6 with argument 0x00FFFFF1 or 0x80FFFFF1 answers 0x920. It then writes buffer words 0 to 15 on 16 consecutive cycles, starting in the first cycle after acceptance. Every word is zero except word 3, which is 0x00000200 (byte 13 = 2, with the lowest byte address in bits 7:0). `data_done_o` pulses in the cycle after the last write. With any other argument, opcode 6 only answers 0x920.
- R12: Opcode 51 answers 0x920. It writes word 0 = 0x00002502 and word 1 = 0x00000000 on two consecutive cycles, then pulses `data_done_o`.
- R13: The mode bit resets to 0 (byte mode). A `mode_wr_i` strobe loads `mode_hc_i`. A command accepted in the same cycle still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 6 | Command opcode |
| cmd_arg_i | input | 32 | Command argument |
| cmd_ready_o | output | 1 | Engine idle and able to take a command |
| len_wr_i | input | 1 | Block length load strobe |
| len_val_i | input | LEN_W | Block length minus one |
| cnt_wr_i | input | 1 | Block count load strobe |
| cnt_val_i | input | CNT_W | Block count minus one |
| mode_wr_i | input | 1 | Mode bit load strobe |
| mode_hc_i | input | 1 | 1 = high-capacity (block) addressing |
| resp_o | output | 128 | Response words, word 0 in bits 31:0 |
| cmd_done_o | output | 1 | Command complete pulse |
| data_done_o | output | 1 | Data phase complete pulse |
| align_warn_o | output | 1 | Misaligned byte offset pulse |
| xfer_req_o | output | 1 | Storage transfer request |
| xfer_wr_o | output | 1 | 1 = write to storage, 0 = read |
| xfer_idx_o | output | 32 | First block index |
| xfer_cnt_o | output | CNT_W | Number of blocks |
| xfer_ack_i | input | 1 | Storage transfer finished |
| buf_we_o | output | 1 | Buffer word write enable |
| buf_waddr_o | output | 4 | Buffer word address |
| buf_wdata_o | output | 32 | Buffer word data |

## Verification
The assertions check the handshake rules on every cycle:
- command-complete follows each acceptance;
- a request holds its index, count and direction until acknowledged;
- data-complete follows only an acknowledge or a final buffer write;
- the engine refuses commands while busy;
- fill addresses step by one;
- the warning appears only together with command-complete.

Response values, the stored length and count with their collision rules, the divided index, the 34-cycle byte-mode latency and the buffer pattern contents depend on values that only a reference model can predict. The bench's scenarios show these by comparing every output against its model on every clock.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OP_W   = 6;

  localparam logic [OP_W-1:0] OP_SWITCH = 6'd6;
  localparam logic [OP_W-1:0] OP_SELECT = 6'd7;
  localparam logic [OP_W-1:0] OP_ECHO   = 6'd8;
  localparam logic [OP_W-1:0] OP_HALT   = 6'd12;
  localparam logic [OP_W-1:0] OP_STATUS = 6'd13;
  localparam logic [OP_W-1:0] OP_BLEN   = 6'd16;
  localparam logic [OP_W-1:0] OP_RD_ONE = 6'd17;
  localparam logic [OP_W-1:0] OP_RD_MUL = 6'd18;
  localparam logic [OP_W-1:0] OP_WR_ONE = 6'd24;
  localparam logic [OP_W-1:0] OP_WR_MUL = 6'd25;
  localparam logic [OP_W-1:0] OP_OPCOND = 6'd41;
  localparam logic [OP_W-1:0] OP_RECORD = 6'd51;
  localparam logic [OP_W-1:0] OP_APP    = 6'd55;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_XFER, ST_FILL} eng_st_e;
  typedef enum logic [1:0] {PAT_NONE, PAT_SWITCH, PAT_RECORD} pat_e;

  typedef struct packed {
    logic [WORD_W-1:0] resp0;
    logic              rw;
    logic              wr;
    logic              one_blk;
    logic              set_len;
    pat_e              pat;
  } dec_t;

  // state code at 12:9, ready at 8, app-command at 5
  function automatic logic [WORD_W-1:0] status_word(input logic [3:0] cur, input logic app);
    return {19'b0, cur, 1'b1, 2'b0, app, 5'b0};
  endfunction

endpackage

// File: rtl/card_cmd_decode.sv
module card_cmd_decode
  import card_cmd_pkg::*;
#(
  parameter logic [WORD_W-1:0] SW_ARG_A = 32'h00FF_FFF1,
  parameter logic [WORD_W-1:0] SW_ARG_B = 32'h80FF_FFF1
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] arg_i,
  output dec_t              dec_o
);

  always_comb begin
    dec_o     = '0;
    dec_o.pat = PAT_NONE;
    case (op_i)
      OP_APP:    dec_o.resp0 = status_word(4'd4, 1'b1);
      OP_SELECT: dec_o.resp0 = status_word(4'd3, 1'b0);
      OP_HALT:   dec_o.resp0 = status_word(4'd5, 1'b0);
      OP_STATUS: dec_o.resp0 = status_word(4'd4, 1'b0);
      OP_BLEN: begin
        dec_o.resp0   = status_word(4'd4, 1'b0);
        dec_o.set_len = 1'b1;
      end
      OP_RD_ONE, OP_RD_MUL, OP_WR_ONE, OP_WR_MUL: begin
        dec_o.resp0   = status_word(4'd4, 1'b0);
        dec_o.rw      = 1'b1;
        dec_o.wr      = (op_i == OP_WR_ONE) || (op_i == OP_WR_MUL);
        dec_o.one_blk = (op_i == OP_RD_ONE) || (op_i == OP_WR_ONE);
      end
      OP_OPCOND: dec_o.resp0 = 32'h80FF_8000;
      OP_ECHO:   dec_o.resp0 = arg_i;
      OP_SWITCH: begin
        dec_o.resp0 = status_word(4'd4, 1'b1);
        if (arg_i == SW_ARG_A || arg_i == SW_ARG_B) dec_o.pat = PAT_SWITCH;
      end
      OP_RECORD: begin
        dec_o.resp0 = status_word(4'd4, 1'b1);
        dec_o.pat   = PAT_RECORD;
      end
      default: dec_o.resp0 = '0;
    endcase
  end

endmodule

// File: rtl/card_blk_div.sv
module card_blk_div #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);

  localparam int unsigned CW = $clog2(NUM_W);

  logic             busy_q, done_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] q_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  // restoring step, one quotient bit per cycle
  assign trial = {rem_q, q_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        den_q  <= den_i;
        q_q    <= num_i;
      end else if (busy_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NUM_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;

endmodule

// File: rtl/card_fill_pat.sv
module card_fill_pat
  import card_cmd_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned MARK_BYTE = 13,
  parameter logic [7:0]  MARK_VAL  = 8'd2,
  parameter logic [WORD_W-1:0] REC_W0 = 32'h0000_2502
) (
  input  pat_e              pat_i,
  input  logic [AW-1:0]     addr_i,
  output logic [WORD_W-1:0] data_o
);

  localparam int unsigned     MARK_WORD = MARK_BYTE / 4;
  localparam logic [WORD_W-1:0] MARK_DATA =
    WORD_W'(MARK_VAL) << (8 * (MARK_BYTE % 4));

  always_comb begin
    data_o = '0;
    case (pat_i)
      PAT_SWITCH: if (addr_i == AW'(MARK_WORD)) data_o = MARK_DATA;
      PAT_RECORD: if (addr_i == '0) data_o = REC_W0;
      default:    data_o = '0;
    endcase
  end

endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
  import card_cmd_pkg::*;
#(
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DEF_LEN  = 512,
  parameter int unsigned ALIGN_LG = 9,
  parameter int unsigned SW_BYTES = 64,
  parameter int unsigned REC_BYTES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [5:0]            cmd_op_i,
  input  logic [31:0]           cmd_arg_i,
  output logic                  cmd_ready_o,
  input  logic                  len_wr_i,
  input  logic [LEN_W-1:0]      len_val_i,
  input  logic                  cnt_wr_i,
  input  logic [CNT_W-1:0]      cnt_val_i,
  input  logic                  mode_wr_i,
  input  logic                  mode_hc_i,
  output logic [127:0]          resp_o,
  output logic                  cmd_done_o,
  output logic                  data_done_o,
  output logic                  align_warn_o,
  output logic                  xfer_req_o,
  output logic                  xfer_wr_o,
  output logic [31:0]           xfer_idx_o,
  output logic [CNT_W-1:0]      xfer_cnt_o,
  input  logic                  xfer_ack_i,
  output logic                  buf_we_o,
  output logic [$clog2(SW_BYTES/4)-1:0] buf_waddr_o,
  output logic [31:0]           buf_wdata_o
);

  localparam int unsigned SW_WORDS  = SW_BYTES / 4;
  localparam int unsigned REC_WORDS = REC_BYTES / 4;
  localparam int unsigned BUF_AW    = $clog2(SW_WORDS);
  localparam int unsigned RESP_W    = 4 * WORD_W;

  eng_st_e           st_q;
  dec_t              dec;
  logic              accept, div_start, div_done, misaligned;
  logic [WORD_W-1:0] div_quot;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  blk_cnt_q, xcnt_q;
  logic              hc_q, xwr_q;
  logic [RESP_W-1:0] resp_q;
  logic              cmd_done_q, data_done_q, warn_q;
  logic [WORD_W-1:0] idx_q;
  logic [BUF_AW-1:0] fill_cnt_q, fill_last;
  pat_e              pat_q;

  card_cmd_decode u_dec (
    .op_i  (cmd_op_i),
    .arg_i (cmd_arg_i),
    .dec_o (dec)
  );

  assign accept     = cmd_valid_i && (st_q == ST_IDLE);
  assign misaligned = |cmd_arg_i[ALIGN_LG-1:0];
  assign div_start  = accept && dec.rw && !hc_q;

  card_blk_div #(.NUM_W(WORD_W), .DEN_W(LEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (cmd_arg_i),
    .den_i   (len_q),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  card_fill_pat #(.AW(BUF_AW)) u_pat (
    .pat_i  (pat_q),
    .addr_i (fill_cnt_q),
    .data_o (buf_wdata_o)
  );

  assign fill_last = (pat_q == PAT_RECORD) ? BUF_AW'(REC_WORDS - 1) : BUF_AW'(SW_WORDS - 1);

  // sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      resp_q      <= '0;
      cmd_done_q  <= 1'b0;
      data_done_q <= 1'b0;
      warn_q      <= 1'b0;
      idx_q       <= '0;
      xcnt_q      <= '0;
      xwr_q       <= 1'b0;
      fill_cnt_q  <= '0;
      pat_q       <= PAT_NONE;
    end else begin
      cmd_done_q  <= 1'b0;
      data_done_q <= 1'b0;
      warn_q      <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            resp_q             <= '0;
            resp_q[WORD_W-1:0] <= dec.resp0;
            cmd_done_q         <= 1'b1;
            if (dec.rw) begin
              xwr_q  <= dec.wr;
              xcnt_q <= dec.one_blk ? CNT_W'(1) : blk_cnt_q;
              warn_q <= !hc_q && misaligned;
              if (hc_q) begin
                idx_q <= cmd_arg_i;
                st_q  <= ST_XFER;
              end else begin
                st_q  <= ST_DIV;
              end
            end else if (dec.pat != PAT_NONE) begin
              pat_q      <= dec.pat;
              fill_cnt_q <= '0;
              st_q       <= ST_FILL;
            end
          end
        end
        ST_DIV: begin
          if (div_done) begin
            idx_q <= div_quot;
            st_q  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_ack_i) begin
            data_done_q <= 1'b1;
            st_q        <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (fill_cnt_q == fill_last) begin
            data_done_q <= 1'b1;
            st_q        <= ST_IDLE;
          end else begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // settings held for the register block; command side wins a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q     <= LEN_W'(DEF_LEN);
      blk_cnt_q <= CNT_W'(1);
      hc_q      <= 1'b0;
    end else begin
      if (accept && dec.set_len)  len_q <= cmd_arg_i[LEN_W-1:0];
      else if (len_wr_i)          len_q <= len_val_i + 1'b1;
      if (accept && dec.one_blk)  blk_cnt_q <= CNT_W'(1);
      else if (cnt_wr_i)          blk_cnt_q <= cnt_val_i + 1'b1;
      if (mode_wr_i)              hc_q <= mode_hc_i;
    end
  end

  assign cmd_ready_o  = (st_q == ST_IDLE);
  assign resp_o       = resp_q;
  assign cmd_done_o   = cmd_done_q;
  assign data_done_o  = data_done_q;
  assign align_warn_o = warn_q;
  assign xfer_req_o   = (st_q == ST_XFER);
  assign xfer_wr_o    = xwr_q;
  assign xfer_idx_o   = idx_q;
  assign xfer_cnt_o   = xcnt_q;
  assign buf_we_o     = (st_q == ST_FILL);
  assign buf_waddr_o  = fill_cnt_q;

endmodule

// File: rtl/card_cmd_chk.sv
module card_cmd_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             cmd_done_o,
  input logic             data_done_o,
  input logic             align_warn_o,
  input logic             xfer_req_o,
  input logic             xfer_ack_i,
  input logic             xfer_wr_o,
  input logic [31:0]      xfer_idx_o,
  input logic [CNT_W-1:0] xfer_cnt_o,
  input logic             buf_we_o,
  input logic [AW-1:0]    buf_waddr_o
);

  logic accept;
  assign accept = cmd_valid_i && cmd_ready_o;

  // R1
  done_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> cmd_done_o);

  // R1
  done_needs_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |-> $past(accept));

  // R10
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o || buf_we_o) |-> !cmd_ready_o);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_idx_o)
                                     && $stable(xfer_cnt_o) && $stable(xfer_wr_o)));

  // R9
  ack_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_ack_i) |=> (!xfer_req_o && data_done_o && cmd_ready_o));

  // R12
  data_done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done_o |-> ($past(xfer_req_o && xfer_ack_i) || $past(buf_we_o)));

  // R8
  warn_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_warn_o |-> cmd_done_o);

  // R11
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && $past(buf_we_o)) |-> (buf_waddr_o == AW'($past(buf_waddr_o) + 1'b1)));

  // R11
  one_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xfer_req_o, buf_we_o}));

endmodule

bind card_cmd_engine card_cmd_chk #(.CNT_W(CNT_W), .AW(BUF_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_done_o   (cmd_done_o),
  .data_done_o  (data_done_o),
  .align_warn_o (align_warn_o),
  .xfer_req_o   (xfer_req_o),
  .xfer_ack_i   (xfer_ack_i),
  .xfer_wr_o    (xfer_wr_o),
  .xfer_idx_o   (xfer_idx_o),
  .xfer_cnt_o   (xfer_cnt_o),
  .buf_we_o     (buf_we_o),
  .buf_waddr_o  (buf_waddr_o)
);

// File: tb/sim_card_cmd_engine.sv
`timescale 1ns/1ps
module sim_card_cmd_engine;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;
  localparam int CNT_W = 16;
  localparam int AW    = 4;
  localparam int DIV_WAIT = 33;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [5:0] cmd_op;
  logic [31:0] cmd_arg;
  logic len_wr, cnt_wr, mode_wr, mode_hc;
  logic [LEN_W-1:0] len_val;
  logic [CNT_W-1:0] cnt_val;
  logic xfer_ack;

  logic cmd_ready_o, cmd_done_o, data_done_o, align_warn_o;
  logic [127:0] resp_o;
  logic xfer_req_o, xfer_wr_o, buf_we_o;
  logic [31:0] xfer_idx_o, buf_wdata_o;
  logic [CNT_W-1:0] xfer_cnt_o;
  logic [AW-1:0] buf_waddr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_arg_i(cmd_arg),
    .cmd_ready_o(cmd_ready_o),
    .len_wr_i(len_wr), .len_val_i(len_val),
    .cnt_wr_i(cnt_wr), .cnt_val_i(cnt_val),
    .mode_wr_i(mode_wr), .mode_hc_i(mode_hc),
    .resp_o(resp_o), .cmd_done_o(cmd_done_o), .data_done_o(data_done_o),
    .align_warn_o(align_warn_o),
    .xfer_req_o(xfer_req_o), .xfer_wr_o(xfer_wr_o), .xfer_idx_o(xfer_idx_o),
    .xfer_cnt_o(xfer_cnt_o), .xfer_ack_i(xfer_ack),
    .buf_we_o(buf_we_o), .buf_waddr_o(buf_waddr_o), .buf_wdata_o(buf_wdata_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int ack_delay = 0;
  int ack_cnt = 0;

  // reference model state
  int m_st;           // 0 idle, 1 dividing, 2 transfer, 3 fill
  int m_wait, m_fill_i, m_fill_n, m_len, m_cnt, m_xcnt;
  bit m_scr, m_cd, m_dd, m_warn, m_wr, m_hc;
  logic [127:0] m_resp;
  logic [31:0]  m_idx;

  function automatic logic [31:0] ref_word(input int op, input logic [31:0] arg);
    case (op)
      55, 6, 51:                return 32'h920;
      7:                        return 32'h700;
      12:                       return 32'hB00;
      13, 16, 17, 18, 24, 25:   return 32'h900;
      41:                       return 32'h80FF8000;
      8:                        return arg;
      default:                  return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ref_fill(input bit scr, input int i);
    if (scr) return (i == 0) ? 32'h00002502 : 32'h0;
    return (i == 3) ? 32'h00000200 : 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit acc;
    int op;
    if (!rst_n) begin
      m_st = 0; m_wait = 0; m_fill_i = 0; m_fill_n = 0;
      m_len = 512; m_cnt = 1; m_xcnt = 0; m_scr = 0;
      m_cd = 0; m_dd = 0; m_warn = 0; m_wr = 0; m_hc = 0;
      m_resp = '0; m_idx = '0;
    end else begin
      acc = cmd_valid && (m_st == 0);
      op  = int'(cmd_op);
      m_cd = 0; m_dd = 0; m_warn = 0;
      case (m_st)
        0: if (acc) begin
          m_resp = {96'h0, ref_word(op, cmd_arg)};
          m_cd = 1;
          if (op inside {17, 18, 24, 25}) begin
            m_wr = (op == 24 || op == 25);
            m_xcnt = (op == 17 || op == 24) ? 1 : m_cnt;
            if (m_hc) begin
              m_idx = cmd_arg; m_st = 2;
            end else begin
              m_idx = (m_len == 0) ? 32'hFFFFFFFF : cmd_arg / m_len;
              m_wait = DIV_WAIT; m_st = 1;
              m_warn = (cmd_arg % 512) != 0;
            end
          end else if (op == 51 || (op == 6 && (cmd_arg == 32'h00FFFFF1 || cmd_arg == 32'h80FFFFF1))) begin
            m_st = 3; m_fill_i = 0; m_scr = (op == 51); m_fill_n = m_scr ? 2 : 16;
          end
        end
        1: begin m_wait--; if (m_wait == 0) m_st = 2; end
        2: if (xfer_ack) begin m_st = 0; m_dd = 1; end
        3: begin m_fill_i++; if (m_fill_i == m_fill_n) begin m_st = 0; m_dd = 1; end end
        default: m_st = 0;
      endcase
      if (acc && op == 16) m_len = int'(cmd_arg) & 4095;
      else if (len_wr)     m_len = (int'(len_val) + 1) & 4095;
      if (acc && (op == 17 || op == 24)) m_cnt = 1;
      else if (cnt_wr)     m_cnt = (int'(cnt_val) + 1) & 65535;
      if (mode_wr) m_hc = mode_hc;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    check(resp_o === m_resp, "R1 R2 R3 response", resp_o, m_resp);
    check(cmd_ready_o === (m_st == 0), "R10 ready", 128'(cmd_ready_o), 128'(m_st == 0));
    check(cmd_done_o === m_cd, "R1 cmd_done", 128'(cmd_done_o), 128'(m_cd));
    check(data_done_o === m_dd, "R9 R11 R12 data_done", 128'(data_done_o), 128'(m_dd));
    check(align_warn_o === m_warn, "R8 warn", 128'(align_warn_o), 128'(m_warn));
    check(xfer_req_o === (m_st == 2), "R6 R7 R9 request", 128'(xfer_req_o), 128'(m_st == 2));
    check(buf_we_o === (m_st == 3), "R11 R12 buffer write", 128'(buf_we_o), 128'(m_st == 3));
    if (m_st == 2) begin
      check(xfer_idx_o === m_idx, "R4 R6 R7 R13 index", 128'(xfer_idx_o), 128'(m_idx));
      check(int'(xfer_cnt_o) == m_xcnt, "R5 count", 128'(xfer_cnt_o), 128'(m_xcnt));
      check(xfer_wr_o === m_wr, "R6 direction", 128'(xfer_wr_o), 128'(m_wr));
    end
    if (m_st == 3) begin
      check(int'(buf_waddr_o) == m_fill_i, "R11 R12 address", 128'(buf_waddr_o), 128'(m_fill_i));
      check(buf_wdata_o === ref_fill(m_scr, m_fill_i), "R11 R12 data",
            128'(buf_wdata_o), 128'(ref_fill(m_scr, m_fill_i)));
    end
  end

  // storage port responder
  always @(negedge clk) begin
    if (xfer_ack) begin
      xfer_ack = 1'b0; ack_cnt = 0;
    end else if (xfer_req_o) begin
      if (ack_cnt >= ack_delay) xfer_ack = 1'b1;
      else ack_cnt++;
    end
  end

  task automatic issue(input logic [5:0] op, input logic [31:0] arg);
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_len(input int v);
    @(negedge clk); len_wr = 1'b1; len_val = LEN_W'(v - 1);
    @(negedge clk); len_wr = 1'b0;
  endtask

  task automatic set_cnt(input int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_val = CNT_W'(v - 1);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic set_mode(input bit hc);
    @(negedge clk); mode_wr = 1'b1; mode_hc = hc;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
    len_wr = 1'b0; len_val = '0; cnt_wr = 1'b0; cnt_val = '0;
    mode_wr = 1'b0; mode_hc = 1'b0; xfer_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R1: status, fixed, echo and unknown opcodes, back to back
    issue(55, 0); issue(7, 0); issue(12, 0); issue(13, 0);
    issue(41, 0); issue(8, 32'hDEAD_BEEF); issue(0, 32'h1);
    issue(2, 0); issue(63, 32'hFFFF_FFFF); issue(6, 32'h1234_5678);
    settle();

    // R7 R4: byte mode read with reset length 512
    ack_delay = 3;
    issue(17, 1024); settle();
    // R5 R8 R10: multi-block read, misaligned, commands while busy
    set_len(100); set_cnt(5);
    issue(18, 1000);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 41; cmd_arg = 0;
    repeat (3) @(negedge clk); cmd_valid = 1'b0;
    settle();
    // R4 via opcode 16, then write
    issue(16, 256); issue(25, 4096); settle();

    // R13 R6: block mode
    set_mode(1'b1);
    ack_delay = 0;
    issue(24, 77); settle();
    issue(25, 513); settle();
    set_cnt(7);
    issue(17, 9); issue(18, 32'hFFFF_FFFF); settle();

    // R11 R12: buffer fills
    issue(6, 32'h00FF_FFF1); settle();
    issue(6, 32'h80FF_FFF1); settle();
    issue(51, 32'h5); settle();

    // R7 R8: zero length in byte mode
    set_mode(1'b0);
    issue(16, 0); issue(17, 5); settle();

    // R4 R5 collisions with command side
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 16; cmd_arg = 32'd256; len_wr = 1'b1; len_val = 12'd99;
    @(negedge clk); cmd_valid = 1'b0; len_wr = 1'b0;
    issue(17, 2048); settle();
    set_cnt(4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 24; cmd_arg = 32'd512; cnt_wr = 1'b1; cnt_val = 16'd9;
    @(negedge clk); cmd_valid = 1'b0; cnt_wr = 1'b0;
    settle();
    issue(25, 768); settle();

    // R13: mode write and command in the same cycle uses old mode
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 17; cmd_arg = 32'd1536; mode_wr = 1'b1; mode_hc = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; mode_wr = 1'b0;
    settle();
    issue(18, 3); settle();

    finish_run();
  end

endmodule